// File: doc/BRIEF.md
# Serial Register Access Port

This block is a three-wire serial slave that gives a host byte-wide read and write access to a bank of configuration registers. The three wires are a serial clock, an active-low select and a single data line that is shared by both directions. The serial clock, select and inbound data are sampled by the block's own system clock, and edges of the serial clock are detected internally. Every transaction opens with an instruction byte that carries a direction flag and a start address. Any number of data bytes may follow, and the register address steps on its own after each byte.

Register 0 controls the port itself. One bit selects the bit order on the wire. The same bit also sets the direction of the automatic address step: the address counts down when the most significant bit comes first and counts up when the least significant bit comes first. A second bit must be set before the block may drive the shared line for a read. Writes land in the target register as soon as the last bit of each byte arrives. Raising the select line at any point drops the port back to waiting for an instruction byte.

Top module: `spi_regbank`

## Requirements
- R1: After select falls, the first 8 rising serial-clock edges shift in an instruction byte. Its bit 7 is the direction (1 = read, 0 = write) and bits 6..0 are the start address. Every later edge belongs to the data phase.
- R2: Inbound data is sampled on the serial clock's rising edge. The outbound bit changes only on a falling edge and stays stable while the serial clock is high.
- R3: In a write, the addressed register takes its new value on the rising edge that carries the 8th bit of each data byte. A byte cut short by select going high writes nothing.
- R4: While select is high, the port returns to the start of the instruction phase, whatever it was doing before.
- R5: Register 0 bit 6 sets the bit order for both the instruction and the data bytes: 0 = MSB first, 1 = LSB first.
- R6: In MSB-first mode the address decrements after each data byte and stays at 0x00 once it gets there.
- R7: In LSB-first mode the address increments after each data byte and stays at 0x7F once it gets there.
- R8: The data-line output enable is high only during the data phase of a read while register 0 bit 7 is 1. It is low during the instruction byte and whenever select is high.
- R9: A change to the bit-order bit takes effect only from the next transaction. The rest of the current transaction keeps the order it started with.
- R10: An active-low asynchronous reset clears every register to 0x00, drives the output enable low and returns the port to the instruction phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Inbound serial data (host to block) |
| sdo | output | 1 | Outbound serial data for reads |
| sdo_oe | output | 1 | Output enable for the shared data line |

## Verification
The bench builds the block with the default 8-bit data width. This gives a 7-bit address and 128 registers, so short multibyte bursts reach both saturation points, 0x00 when counting down and 0x7F when counting up. Because register 0 is itself in the bank, descending bursts can overwrite the control bits in the middle of a transaction. This is what lets the bench exercise R9 and the loss of readback.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
  typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_e;
  localparam int unsigned CTRL_BIT_LSB  = 6;
  localparam int unsigned CTRL_BIT_RDEN = 7;
endpackage

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
  assign fall = ~din & din_q;
endmodule

// File: rtl/spi_addr_step.sv
module spi_addr_step #(
  parameter int unsigned AW = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic          up_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  // saturating step: up toward all-ones, down toward zero
  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic up);
    if (up) return (a == TOP) ? a : a + AW'(1);
    else    return (a == '0)  ? a : a - AW'(1);
  endfunction

  assign addr_o = step(addr_i, up_i);
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctrl
);
  localparam int unsigned NREG = 2 ** AW;

  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= '0;
      else if (we && waddr == AW'(g))   q <= wdata;
    end
    assign mem[g] = q;
  end

  assign rdata = mem[raddr];
  assign ctrl  = mem[0];
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_regbank_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int unsigned AW = DW - 1;
  localparam int unsigned CW = $clog2(DW);

  logic          sclk_rise, sclk_fall;
  phase_e        phase;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg, byte_in, rd_data, ctrl;
  logic          rd_mode, lsb_q;
  logic [AW-1:0] addr, addr_next;
  logic [CW-1:0] out_idx;

  // named events for the checker
  logic sample, byte_done, wr_en, in_data, rden;

  spi_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  spi_addr_step #(.AW(AW)) u_step (
    .addr_i(addr), .up_i(lsb_q), .addr_o(addr_next)
  );

  spi_reg_file #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(addr), .wdata(byte_in),
    .raddr(addr), .rdata(rd_data), .ctrl(ctrl)
  );

  assign in_data   = (phase == PH_DATA);
  assign rden      = ctrl[CTRL_BIT_RDEN];
  assign sample    = sclk_rise & ~cs_n;
  assign byte_in   = lsb_q ? {sdi, shreg[DW-1:1]} : {shreg[DW-2:0], sdi};
  assign byte_done = sample && (bit_cnt == CW'(DW-1));
  assign wr_en     = byte_done && in_data && !rd_mode;
  assign out_idx   = lsb_q ? bit_cnt : CW'(DW-1) - bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
      shreg   <= '0;
      rd_mode <= 1'b0;
      addr    <= '0;
      lsb_q   <= 1'b0;
    end else if (cs_n) begin
      phase   <= PH_INSTR;
      bit_cnt <= '0;
      lsb_q   <= ctrl[CTRL_BIT_LSB];   // order frozen for the next transaction
    end else if (sample) begin
      shreg   <= byte_in;
      bit_cnt <= byte_done ? '0 : bit_cnt + CW'(1);
      if (byte_done) begin
        if (!in_data) begin
          rd_mode <= byte_in[DW-1];
          addr    <= byte_in[AW-1:0];
          phase   <= PH_DATA;
        end else begin
          addr    <= addr_next;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               sdo <= 1'b0;
    else if (cs_n)                            sdo <= 1'b0;
    else if (sclk_fall && in_data && rd_mode) sdo <= rd_data[out_idx];
  end

  assign sdo_oe = ~cs_n & in_data & rd_mode & rden;
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int unsigned AW = 7,
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk_rise,
  input logic          sclk_fall,
  input logic          byte_done,
  input logic          in_data,
  input logic          lsb_q,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] bit_cnt,
  input logic          wr_en,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          rden
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !cs_n) |=> $stable(sdo));

  p_write_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (sclk_rise && !cs_n && in_data));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!in_data && bit_cnt == '0));

  p_dec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && !lsb_q && addr != '0) |=> (addr == $past(addr) - AW'(1)));

  p_dec_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && !lsb_q && addr == '0) |=> (addr == '0));

  p_inc_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && lsb_q && addr == TOP) |=> (addr == TOP));

  p_hiz_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);

  p_oe_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (rden && in_data));

  p_order_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> (cs_n || $stable(lsb_q)));
endmodule

bind spi_regbank spi_regbank_chk #(.AW(AW), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .byte_done(byte_done), .in_data(in_data), .lsb_q(lsb_q), .addr(addr),
  .bit_cnt(bit_cnt), .wr_en(wr_en), .sdo(sdo), .sdo_oe(sdo_oe), .rden(rden)
);

// File: tb/test_spi_regbank.sv
module test_spi_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] model [128];
  logic [7:0] wbuf [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_regbank i_spi_regbank (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic logic [6:0] nxt(input logic [6:0] a, input logic up);
    if (up) return (a == 7'h7F) ? 7'h7F : a + 7'd1;
    return (a == 7'h00) ? 7'h00 : a - 7'd1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic rb, output logic oe, output logic stab);
    sdi = b;
    tick(2);
    rb = sdo;
    oe = sdo_oe;
    sclk = 1'b1;
    tick(3);
    stab = (sdo === rb);
    sclk = 1'b0;
    tick(3);
  endtask

  task automatic xbyte(input logic [7:0] tx, input logic lsb, output logic [7:0] rx,
                       output logic oe_any, output logic oe_all, output logic stab_all);
    logic rb, oe, st;
    oe_any = 1'b0; oe_all = 1'b1; stab_all = 1'b1; rx = '0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      bit_io(tx[idx], rb, oe, st);
      rx[idx] = rb;
      oe_any |= oe; oe_all &= oe; stab_all &= st;
    end
  endtask

  task automatic do_write(input logic [6:0] addr, input int n);
    logic lsb, a_, b_, c_;
    logic [7:0] rx;
    logic [6:0] a;
    lsb = model[0][6];
    a = addr;
    cs_n = 1'b0; tick(2);
    xbyte({1'b0, addr}, lsb, rx, a_, b_, c_);
    for (int k = 0; k < n; k++) begin
      xbyte(wbuf[k], lsb, rx, a_, b_, c_);
      model[a] = wbuf[k];
      a = nxt(a, lsb);
    end
    cs_n = 1'b1; tick(3);
  endtask

  task automatic do_read(input logic [6:0] addr, input int n, input string tag);
    logic lsb, rd, oe_any, oe_all, stab;
    logic [7:0] rx;
    logic [6:0] a;
    lsb = model[0][6];
    rd = model[0][7];
    a = addr;
    cs_n = 1'b0; tick(2);
    xbyte({1'b1, addr}, lsb, rx, oe_any, oe_all, stab);
    check("R8 oe in instruction", {7'b0, oe_any}, 8'h00);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, lsb, rx, oe_any, oe_all, stab);
      if (rd) begin
        check(tag, rx, model[a]);
        check("R2 sdo stable while sclk high", {7'b0, stab}, 8'h01);
        check("R8 oe in read data", {7'b0, oe_all}, 8'h01);
      end else begin
        check("R8 oe without readback enable", {7'b0, oe_any}, 8'h00);
      end
      a = nxt(a, lsb);
    end
    cs_n = 1'b1; tick(3);
  endtask

  task automatic partial(input int nbits);
    logic rb, oe, st;
    cs_n = 1'b0; tick(2);
    for (int i = 0; i < nbits; i++) bit_io(1'b1, rb, oe, st);
    cs_n = 1'b1; tick(3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] rx;
    logic a_, b_, c_;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    tick(4);
    check("R10 oe in reset", {7'b0, sdo_oe}, 8'h00);
    rst_n = 1'b1;
    tick(3);
    check("R10 sdo after reset", {7'b0, sdo}, 8'h00);
    do_read(7'h05, 2, "R8");                   // readback disabled: line stays released
    wbuf[0] = 8'h80; do_write(7'h00, 1);       // enable readback, MSB first
    do_read(7'h43, 4, "R10");                  // cleared registers read zero

    // R1 / R6: descending write, then saturation at 0x00
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C; do_write(7'h05, 3);
    do_read(7'h05, 3, "R1");
    wbuf[0] = 8'hA5; wbuf[1] = 8'h11; wbuf[2] = 8'h80; do_write(7'h01, 3);
    do_read(7'h01, 3, "R6");
    check("R6 reg0 saturated write", model[0], 8'h80);

    // R5 / R7: switch to LSB first, ascending saturation at 0x7F
    wbuf[0] = 8'hC0; do_write(7'h00, 1);
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56; do_write(7'h7E, 3);
    do_read(7'h7E, 3, "R7");
    check("R7 top register holds last byte", model[7'h7F], 8'h56);
    do_read(7'h04, 2, "R5");

    // R9: switch back to MSB inside an LSB burst; second byte still LSB order
    wbuf[0] = 8'h80; wbuf[1] = 8'h77; do_write(7'h00, 2);
    do_read(7'h01, 1, "R9");
    do_read(7'h00, 1, "R9");

    // R3: completed byte lands, truncated byte does not
    cs_n = 1'b0; tick(2);
    xbyte({1'b0, 7'h20}, 1'b0, rx, a_, b_, c_);
    xbyte(8'h3C, 1'b0, rx, a_, b_, c_);
    model[7'h20] = 8'h3C;
    begin
      logic rb, oe, st;
      for (int i = 0; i < 4; i++) bit_io(1'b1, rb, oe, st);
    end
    cs_n = 1'b1; tick(3);
    do_read(7'h20, 2, "R3");

    // R4: aborted instruction, then a clean transaction
    partial(5);
    do_read(7'h05, 1, "R4");
    partial(11);
    do_read(7'h7E, 2, "R4");

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [6:0] a;
      int n;
      if (!model[0][7] || ($urandom % 4) == 0) begin
        wbuf[0] = {1'b1, 1'($urandom), 6'($urandom)};
        do_write(7'h00, 1);
      end
      a = 7'($urandom);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(a, n);
      do_read(a, n, "R5");
      if (($urandom % 3) == 0) do_read(7'($urandom), 2, "R1");
    end

    disable watchdog;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule